// File: doc/BRIEF.md
# SIMD Lane-Partitioned Integer Adder

This block adds two 128-bit operand vectors element by element, treating them as sixteen 8-bit, eight 16-bit, four 32-bit or two 64-bit integer lanes. Each lane wraps on overflow and no flag is produced. A single 128-bit adder is built from 8-bit slices. The carry between two slices is forced to zero wherever a lane boundary falls for the size chosen at run time.

A small front end decodes a 32-bit integer vector-add instruction word. It extracts the lane size, the 64-bit (doubleword) or 128-bit (quadword) form, and the three 5-bit register numbers. It flags words whose fixed bits do not match. It also flags quadword forms that name an odd register. The operands and the word are captured on an `in_valid` pulse. The sum and the decoded fields appear one clock later with `out_valid` high, and they hold until the next capture.

Top module: `simd_lane_adder`

## Requirements
- R1: Instruction bits [21:20] select the lane width: 00 gives 8-bit lanes, 01 gives 16-bit, 10 gives 32-bit and 11 gives 64-bit. Each lane result equals the sum of the two operand lanes modulo 2 to the power of the lane width.
- R2: No carry crosses a lane boundary. All-ones plus one in every lane gives all-zero lanes for every size.
- R3: Instruction bit 6 set selects the quadword form, which adds all 128 bits. Bit 6 clear selects the doubleword form, which adds bits [63:0] only and drives result bits [127:64] to zero.
- R4: A word is accepted only if bits [31:25]=1111001, bit 24=0, bit 23=0, bits [11:8]=1000 and bit 4=0. Any other word raises `out_reject`, and its result is all zeros.
- R5: The decoded fields are reported as follows. `out_rd` = {bit 22, bits [15:12]}, `out_rn` = {bit 7, bits [19:16]}, `out_rm` = {bit 5, bits [3:0]}, `out_size` = bits [21:20] and `out_quad` = bit 6.
- R6: An accepted quadword word with an odd `out_rd`, `out_rn` or `out_rm` raises `out_undef`, and its result is all zeros. `out_undef` is never set for a doubleword word or a rejected word.
- R7: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and low otherwise.
- R8: While `in_valid` is low, the result and decode outputs keep their last captured values.
- R9: Asserting `rst_n` low clears `out_valid`, the result and all decode outputs at once, without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Capture strobe for the word and operands |
| in_instr | input | 32 | Instruction word to decode |
| in_opa | input | 128 | First operand vector |
| in_opb | input | 128 | Second operand vector |
| out_valid | output | 1 | Result valid, one cycle after capture |
| out_result | output | 128 | Lane-wise sum |
| out_size | output | 2 | Decoded lane size code |
| out_quad | output | 1 | 1 = quadword form, 0 = doubleword form |
| out_rd | output | 5 | Destination register number |
| out_rn | output | 5 | First source register number |
| out_rm | output | 5 | Second source register number |
| out_reject | output | 1 | Word does not match the fixed pattern |
| out_undef | output | 1 | Quadword form with an odd register number |

## Verification
A faulty boundary mask or a wrong carry gate shows up on `out_result` in the very next valid cycle. An all-ones-plus-one vector makes it visible as a stray 1 in the low bit of the next lane. A decode slip shows on the field outputs or on the reject and undefined flags in that same cycle, together with a zeroed or non-zeroed result. A broken capture enable shows as outputs that change during idle cycles right after a result.

// File: rtl/sla_pkg.sv
package sla_pkg;

  localparam int INSTR_W = 32;
  localparam int REG_W   = 5;

  typedef enum logic [1:0] {
    LANE_B8  = 2'b00,
    LANE_B16 = 2'b01,
    LANE_B32 = 2'b10,
    LANE_B64 = 2'b11
  } lane_size_e;

  typedef struct packed {
    lane_size_e       size;
    logic             quad;
    logic [REG_W-1:0] rd;
    logic [REG_W-1:0] rn;
    logic [REG_W-1:0] rm;
    logic             reject;
    logic             undef;
  } dec_t;

  // fixed-bit patterns of the accepted word
  localparam logic [6:0] MAJOR_PAT = 7'b1111001;
  localparam logic [3:0] OPC_PAT   = 4'b1000;

endpackage

// File: rtl/sla_decode.sv
module sla_decode
  import sla_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);

  logic pat_ok;
  logic any_odd;

  always_comb begin
    pat_ok = (instr[31:25] == MAJOR_PAT) && !instr[24] && !instr[23] &&
             (instr[11:8] == OPC_PAT) && !instr[4];

    dec.size   = lane_size_e'(instr[21:20]);
    dec.quad   = instr[6];
    dec.rd     = {instr[22], instr[15:12]};
    dec.rn     = {instr[7],  instr[19:16]};
    dec.rm     = {instr[5],  instr[3:0]};

    any_odd    = instr[12] | instr[16] | instr[0];
    dec.reject = !pat_ok;
    dec.undef  = pat_ok && instr[6] && any_odd;
  end

endmodule

// File: rtl/sla_lane_add.sv
module sla_lane_add
  import sla_pkg::*;
#(
  parameter int DATA_W  = 128,
  parameter int SLICE_W = 8
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  lane_size_e        size,
  output logic [DATA_W-1:0] sum
);

  localparam int NSLICE = DATA_W / SLICE_W;
  localparam int IDX_W  = (NSLICE > 1) ? $clog2(NSLICE) : 1;

  logic [IDX_W-1:0]  lane_mask;
  logic [NSLICE-1:0] boundary;
  logic [NSLICE-1:0] cin;
  logic [NSLICE-2:0] cout;

  // a slice starts a lane when its index is a multiple of slices-per-lane
  always_comb begin
    lane_mask = (IDX_W'(1) << size) - IDX_W'(1);
    for (int k = 0; k < NSLICE; k++) begin
      boundary[k] = ((IDX_W'(k) & lane_mask) == '0);
    end
  end

  generate
    for (genvar k = 0; k < NSLICE; k++) begin : g_slice
      logic [SLICE_W-1:0] sa;
      logic [SLICE_W-1:0] sb;
      assign sa = opa[k*SLICE_W +: SLICE_W];
      assign sb = opb[k*SLICE_W +: SLICE_W];

      if (k == 0) begin : g_first
        assign cin[k] = 1'b0;
      end else begin : g_chain
        assign cin[k] = boundary[k] ? 1'b0 : cout[k-1];
      end

      if (k == NSLICE-1) begin : g_top
        assign sum[k*SLICE_W +: SLICE_W] = sa + sb + {{(SLICE_W-1){1'b0}}, cin[k]};
      end else begin : g_mid
        assign {cout[k], sum[k*SLICE_W +: SLICE_W]} =
          {1'b0, sa} + {1'b0, sb} + {{SLICE_W{1'b0}}, cin[k]};
      end
    end
  endgenerate

endmodule

// File: rtl/simd_lane_adder.sv
module simd_lane_adder
  import sla_pkg::*;
#(
  parameter int DATA_W  = 128,
  parameter int SLICE_W = 8,
  parameter int HALF_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       in_instr,
  input  logic [DATA_W-1:0] in_opa,
  input  logic [DATA_W-1:0] in_opb,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic [1:0]        out_size,
  output logic              out_quad,
  output logic [4:0]        out_rd,
  output logic [4:0]        out_rn,
  output logic [4:0]        out_rm,
  output logic              out_reject,
  output logic              out_undef
);

  localparam int UPPER_W = DATA_W - HALF_W;

  dec_t              dec;
  logic [DATA_W-1:0] raw_sum;
  logic [DATA_W-1:0] res_nxt;
  logic              vld_q;
  logic [DATA_W-1:0] res_q;
  dec_t              dec_q;

  sla_decode u_dec (
    .instr (in_instr),
    .dec   (dec)
  );

  sla_lane_add #(
    .DATA_W  (DATA_W),
    .SLICE_W (SLICE_W)
  ) u_add (
    .opa  (in_opa),
    .opb  (in_opb),
    .size (dec.size),
    .sum  (raw_sum)
  );

  // next-state: form selection and illegal-word zeroing
  always_comb begin
    res_nxt = raw_sum;
    if (!dec.quad) begin
      res_nxt[DATA_W-1:HALF_W] = '0;
    end
    if (dec.reject || dec.undef) begin
      res_nxt = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      dec_q <= '0;
    end else if (in_valid) begin
      res_q <= res_nxt;
      dec_q <= dec;
    end
  end

  assign out_valid  = vld_q;
  assign out_result = res_q;
  assign out_size   = dec_q.size;
  assign out_quad   = dec_q.quad;
  assign out_rd     = dec_q.rd;
  assign out_rn     = dec_q.rn;
  assign out_rm     = dec_q.rm;
  assign out_reject = dec_q.reject;
  assign out_undef  = dec_q.undef;

  p_valid_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_dword_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_quad) |-> (out_result[DATA_W-1:HALF_W] == {UPPER_W{1'b0}}));
  p_bad_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_reject || out_undef)) |-> (out_result == '0));
  p_flag_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_reject, out_undef}));
  p_undef_quad_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_undef |-> out_quad);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_result) && $stable(out_rd) && $stable(out_size)));

endmodule

// File: tb/simd_lane_adder_bench.sv
module simd_lane_adder_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [31:0]  in_instr = '0;
  logic [127:0] in_opa = '0;
  logic [127:0] in_opb = '0;
  logic         out_valid;
  logic [127:0] out_result;
  logic [1:0]   out_size;
  logic         out_quad;
  logic [4:0]   out_rd, out_rn, out_rm;
  logic         out_reject, out_undef;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  simd_lane_adder u_simd_lane_adder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
    .in_opa(in_opa), .in_opb(in_opb), .out_valid(out_valid),
    .out_result(out_result), .out_size(out_size), .out_quad(out_quad),
    .out_rd(out_rd), .out_rn(out_rn), .out_rm(out_rm),
    .out_reject(out_reject), .out_undef(out_undef)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [1:0] sz, input logic q,
                                     input logic [4:0] d, input logic [4:0] n,
                                     input logic [4:0] m);
    logic [31:0] w;
    w = 32'hF2000800;
    w[21:20] = sz; w[6] = q;
    w[22] = d[4]; w[15:12] = d[3:0];
    w[7]  = n[4]; w[19:16] = n[3:0];
    w[5]  = m[4]; w[3:0]   = m[3:0];
    return w;
  endfunction

  function automatic bit ref_reject(input logic [31:0] w);
    return !((w[31:25] == 7'b1111001) && !w[24] && !w[23] && (w[11:8] == 4'b1000) && !w[4]);
  endfunction

  function automatic bit ref_undef(input logic [31:0] w);
    return !ref_reject(w) && w[6] && (w[12] || w[16] || w[0]);
  endfunction

  function automatic logic [127:0] ref_sum(input logic [31:0] w, input logic [127:0] a,
                                           input logic [127:0] b);
    int lw;
    int span;
    logic [128:0] msk;
    logic [128:0] la, lb, s;
    logic [127:0] r;
    r = '0;
    if (ref_reject(w) || ref_undef(w)) return r;
    lw = 8 << w[21:20];
    span = w[6] ? 128 : 64;
    msk = (129'd1 << lw) - 129'd1;
    for (int e = 0; e < span / lw; e++) begin
      la = ({1'b0, a} >> (e * lw)) & msk;
      lb = ({1'b0, b} >> (e * lw)) & msk;
      s  = (la + lb) & msk;
      r  = r | 128'(s << (e * lw));
    end
    return r;
  endfunction

  task automatic run_op(input string req, input logic [31:0] w,
                        input logic [127:0] a, input logic [127:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_instr = w; in_opa = a; in_opb = b;
    @(negedge clk);
    in_valid = 1'b0;
    in_instr = ~w; in_opa = ~a; in_opb = b ^ a;
    chk({req, " R7 valid"}, 128'(out_valid), 128'(1));
    chk({req, " result"}, out_result, ref_sum(w, a, b));
    chk({req, " R4 reject"}, 128'(out_reject), 128'(ref_reject(w)));
    chk({req, " R6 undef"}, 128'(out_undef), 128'(ref_undef(w)));
    chk({req, " R5 fields"}, 128'({out_size, out_quad, out_rd, out_rn, out_rm}),
        128'({w[21:20], w[6], w[22], w[15:12], w[7], w[19:16], w[5], w[3:0]}));
  endtask

  logic [127:0] ones, one_each;

  initial begin
    void'($urandom(32'd20240611));
    #5;
    chk("R9 reset valid", 128'(out_valid), 128'(0));
    chk("R9 reset result", out_result, 128'(0));
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    ones = '1;
    // R2: all-ones plus one per lane, each size, quad form
    for (int sz = 0; sz < 4; sz++) begin
      one_each = '0;
      for (int e = 0; e < 128 / (8 << sz); e++) one_each[e * (8 << sz)] = 1'b1;
      run_op("R2 carry stop", mk(2'(sz), 1'b1, 5'd0, 5'd2, 5'd4), ones, one_each);
      chk("R2 zero lanes", out_result, 128'(0));
    end
    // R1: distinct pattern per size
    for (int sz = 0; sz < 4; sz++)
      run_op("R1 size", mk(2'(sz), 1'b1, 5'd6, 5'd8, 5'd10),
             128'h80FF_7F01_FFFF_0000_8000_0000_FFFF_FFFF, 128'h80FF_0101_0001_FFFF_8000_0001_0000_0001);
    // R3: doubleword form
    run_op("R3 dword", mk(2'b11, 1'b0, 5'd1, 5'd3, 5'd5), ones, ones);
    chk("R3 upper zero", out_result[127:64], '0);
    // R4: each fixed bit flipped
    run_op("R4 bit24", mk(2'b00, 1'b0, 5'd1, 5'd2, 5'd3) | 32'h0100_0000, ones, ones);
    run_op("R4 bit4", mk(2'b01, 1'b0, 5'd1, 5'd2, 5'd3) | 32'h0000_0010, ones, ones);
    run_op("R4 opc", mk(2'b01, 1'b1, 5'd0, 5'd2, 5'd4) ^ 32'h0000_0500, ones, ones);
    // R6: each odd register in quad form
    run_op("R6 rd odd", mk(2'b10, 1'b1, 5'd17, 5'd2, 5'd4), ones, ones);
    run_op("R6 rn odd", mk(2'b10, 1'b1, 5'd16, 5'd3, 5'd4), ones, ones);
    run_op("R6 rm odd", mk(2'b10, 1'b1, 5'd16, 5'd2, 5'd31), ones, ones);
    run_op("R6 dword odd ok", mk(2'b10, 1'b0, 5'd31, 5'd31, 5'd31), ones, ones);
    // R7/R8: idle cycles after a result
    run_op("R8 base", mk(2'b00, 1'b1, 5'd2, 5'd4, 5'd6), 128'h1234, 128'h5678);
    @(negedge clk);
    chk("R7 valid low idle", 128'(out_valid), 128'(0));
    chk("R8 hold result", out_result, 128'h68AC);
    chk("R8 hold rd", 128'(out_rd), 128'(2));
    // random
    for (int i = 0; i < 300; i++) begin
      logic [31:0] w;
      logic [4:0] d, n, m;
      d = 5'($urandom); n = 5'($urandom); m = 5'($urandom);
      if ($urandom % 2 == 0) begin d[0] = 0; n[0] = 0; m[0] = 0; end
      w = mk(2'($urandom), 1'($urandom), d, n, m);
      if ($urandom % 8 == 0) w = w ^ (32'd1 << ($urandom % 32));
      run_op("R1 random", w, {$urandom, $urandom, $urandom, $urandom},
             {$urandom, $urandom, $urandom, $urandom});
    end
    // R9: asynchronous reset mid-run
    @(negedge clk);
    in_valid = 1'b1; in_instr = mk(2'b00, 1'b1, 5'd0, 5'd0, 5'd0);
    @(negedge clk);
    #3 rst_n = 1'b0;
    #1;
    chk("R9 async valid", 128'(out_valid), 128'(0));
    chk("R9 async result", out_result, 128'(0));
    chk("R9 async fields", 128'({out_rd, out_quad}), 128'(0));
    in_valid = 1'b0;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule